// File: doc/BRIEF.md
# Serial Gain-Word Control Port

This block is the device side of a four-wire serial port that sets and reports the gain code of one variable-gain channel. A controller pulls the active-low select line low and clocks one 8-bit frame in on serial data in. The first bit picks the direction of the access. The second bit is a spacer and carries no meaning. The last six bits are the gain code. A write frame is committed to the gain holding register when select returns high. A read frame shifts the held code back out on serial data out.

The held code covers 42 settings, one per dB from -9 dB to +32 dB. The block drives it out as a raw code and also as a signed dB value. All four port inputs are sampled by the core clock. The controller's serial clock must therefore run well below the core clock (each serial half-period lasts at least four core cycles), and the inputs must come from the core clock domain or from an external synchronizer.

The frame engine runs as a state machine:
- `ST_IDLE`: select is high.
- `ST_MODE`: select has fallen and the mode bit is awaited.
- `ST_SKIP`: the spacer bit is awaited.
- `ST_WDATA` and `ST_RDATA`: the six code bits are moved in or out.
- `ST_WFULL`: exactly eight write bits have arrived.
- `ST_HOLD`: the frame is finished or has run too long, and the engine waits for select to rise.

Transitions:
- A select fall moves `ST_IDLE` to `ST_MODE`.
- Each serial rising edge advances `ST_MODE` to `ST_SKIP`, `ST_SKIP` to `ST_WDATA` or `ST_RDATA`, the sixth data edge to `ST_WFULL` (write) or `ST_HOLD` (read), and a ninth write edge from `ST_WFULL` to `ST_HOLD`.
- A select rise returns every state to `ST_IDLE`. Only the rise from `ST_WFULL` commits the code.

Top module: `gain_word_port`

## Requirements
- R1: After reset, gain_code is 0, gain_db is -9, and sdo is low.
- R2: While latch_n is high, edges on sclk and any value on sdi have no effect: gain_code stays unchanged and sdo stays low.
- R3: Serial bits are taken on the rising edge of sclk. The first bit after latch_n falls is the mode bit: 0 selects a write and 1 selects a read.
- R4: The second bit of a frame is ignored. Write and read results are the same whether it is 0 or 1.
- R5: In a write frame, bits 3 to 8 form the gain code, most significant bit first. The code appears on gain_code after latch_n rises, provided exactly 8 rising sclk edges occurred while latch_n was low.
- R6: A write frame with fewer or more than 8 rising sclk edges is discarded, and gain_code keeps its previous value.
- R7: A written code above 41 is stored as 41. gain_code never exceeds 41.
- R8: gain_db is the 7-bit two's complement value gain_code minus 9, ranging from -9 to +32.
- R9: In a read frame, the held code is driven on sdo least significant bit first. Each bit changes after a falling sclk edge. Bit 0 follows the falling edge that comes after the second rising edge, so the controller samples code bits 0 to 5 at rising edges 3 to 8. A read does not change gain_code.
- R10: sdo is low at all times outside the data phase of a read frame, including during write frames and during the mode and spacer bits of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all port inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data from the controller |
| latch_n | input | 1 | Active-low frame select |
| sdo | output | 1 | Serial readback data |
| gain_code | output | 6 | Held gain code, 0 to 41 |
| gain_db | output | 7 | Held gain in dB, signed, code minus 9 |

## Verification
The bench sends frames one bit short and one bit long. A design that commits on the sixth data bit, or that keeps counting past eight, would change the gain on those frames. The bench writes codes 1 and 32 to catch a reversed shift order, and codes 42 and 63 to catch missing saturation. It flips the spacer bit on both writes and reads, which exposes a design that shifts the spacer into the code. It compares readback bit by bit at rising edges 3 to 8, so an off-by-one in the output phase or an MSB-first readback gives a wrong bit. It also toggles sclk with select high to expose a port that does not gate on select.

// File: rtl/gwp_pkg.sv
package gwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_SKIP,
        ST_WDATA,
        ST_WFULL,
        ST_RDATA,
        ST_HOLD
    } gwp_state_e;

endpackage

// File: rtl/gwp_sampler.sv
module gwp_sampler #(
    parameter int          N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] cur_q;
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q[i]  <= RST_VAL[i];
                prev_q[i] <= RST_VAL[i];
            end else begin
                cur_q[i]  <= din[i];
                prev_q[i] <= cur_q[i];
            end
        end
        assign rise[i] = cur_q[i] & ~prev_q[i];
        assign fall[i] = ~cur_q[i] & prev_q[i];
    end

endmodule

// File: rtl/gwp_frame_fsm.sv
module gwp_frame_fsm
    import gwp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sel_fall,
    input  logic              sel_rise,
    input  logic              sdi_q,
    input  logic [CODE_W-1:0] held_code,
    output logic              commit,
    output logic [CODE_W-1:0] wr_word,
    output logic              sdo
);

    localparam int CNT_W = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);

    gwp_state_e        st, st_nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  rd_idx;
    logic [CODE_W-1:0] shreg;
    logic              mode_rd;
    logic              sdo_q;

    always_comb begin
        st_nxt = st;
        commit = 1'b0;
        unique case (st)
            ST_IDLE:  if (sel_fall) st_nxt = ST_MODE;
            ST_MODE:  if (sclk_rise) st_nxt = ST_SKIP;
            ST_SKIP:  if (sclk_rise) st_nxt = mode_rd ? ST_RDATA : ST_WDATA;
            ST_WDATA: if (sclk_rise && bit_cnt == LAST_BIT) st_nxt = ST_WFULL;
            ST_WFULL: if (sclk_rise) st_nxt = ST_HOLD;
            ST_RDATA: if (sclk_rise && bit_cnt == LAST_BIT) st_nxt = ST_HOLD;
            ST_HOLD:  st_nxt = ST_HOLD;
            default:  st_nxt = ST_IDLE;
        endcase
        if (sel_rise) begin
            commit = (st == ST_WFULL);
            st_nxt = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rd_idx  <= '0;
            shreg   <= '0;
            mode_rd <= 1'b0;
            sdo_q   <= 1'b0;
        end else begin
            if (st == ST_MODE && sclk_rise)
                mode_rd <= sdi_q;
            if (st != ST_WDATA && st != ST_RDATA)
                bit_cnt <= '0;
            else if (sclk_rise)
                bit_cnt <= bit_cnt + 1'b1;
            if (st == ST_WDATA && sclk_rise)
                shreg <= {shreg[CODE_W-2:0], sdi_q};
            if (st == ST_RDATA) begin
                if (sclk_fall && rd_idx < CNT_W'(CODE_W)) begin
                    sdo_q  <= held_code[rd_idx];
                    rd_idx <= rd_idx + 1'b1;
                end
            end else begin
                sdo_q  <= 1'b0;
                rd_idx <= '0;
            end
        end
    end

    assign wr_word = shreg;
    assign sdo     = (st == ST_RDATA) ? sdo_q : 1'b0;

endmodule

// File: rtl/gwp_gain_hold.sv
module gwp_gain_hold #(
    parameter int CODE_W    = 6,
    parameter int MAX_CODE  = 41,
    parameter int DB_OFFSET = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [CODE_W-1:0]   wr_word,
    output logic [CODE_W-1:0]   code,
    output logic signed [CODE_W:0] db
);

    localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(MAX_CODE);
    localparam logic [CODE_W:0]   DB_SHIFT = (CODE_W + 1)'(DB_OFFSET);

    logic [CODE_W-1:0] clipped;

    always_comb begin
        clipped = (wr_word > CODE_TOP) ? CODE_TOP : wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      code <= '0;
        else if (commit) code <= clipped;
    end

    assign db = $signed({1'b0, code} - DB_SHIFT);

endmodule

// File: rtl/gain_word_port.sv
module gain_word_port #(
    parameter int CODE_W    = 6,
    parameter int MAX_CODE  = 41,
    parameter int DB_OFFSET = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   sdi,
    input  logic                   latch_n,
    output logic                   sdo,
    output logic [CODE_W-1:0]      gain_code,
    output logic signed [CODE_W:0] gain_db
);

    logic [1:0]        rise, fall;
    logic              sdi_q;
    logic              commit;
    logic [CODE_W-1:0] wr_word;

    gwp_sampler #(.N(2), .RST_VAL(2'b10)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({latch_n, sclk}),
        .rise  (rise),
        .fall  (fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sdi_q <= 1'b0;
        else        sdi_q <= sdi;
    end

    gwp_frame_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (rise[0]),
        .sclk_fall (fall[0]),
        .sel_fall  (fall[1]),
        .sel_rise  (rise[1]),
        .sdi_q     (sdi_q),
        .held_code (gain_code),
        .commit    (commit),
        .wr_word   (wr_word),
        .sdo       (sdo)
    );

    gwp_gain_hold #(
        .CODE_W    (CODE_W),
        .MAX_CODE  (MAX_CODE),
        .DB_OFFSET (DB_OFFSET)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wr_word (wr_word),
        .code    (gain_code),
        .db      (gain_db)
    );

endmodule

// File: rtl/gwp_checker.sv
module gwp_checker #(
    parameter int CODE_W    = 6,
    parameter int MAX_CODE  = 41,
    parameter int DB_OFFSET = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   latch_n,
    input logic                   sdo,
    input logic [CODE_W-1:0]      gain_code,
    input logic signed [CODE_W:0] gain_db
);

    assert_reset_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (gain_code == '0));

    assert_code_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gain_code <= CODE_W'(MAX_CODE));

    assert_db_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_db >= -(CODE_W + 1)'(DB_OFFSET)) &&
        (gain_db <= (CODE_W + 1)'(MAX_CODE - DB_OFFSET)));

    assert_gain_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_n && $past(!latch_n) && $past(!latch_n, 2) && $past(!latch_n, 3))
        |-> $stable(gain_code));

    assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_n && $past(latch_n) && $past(latch_n, 2) && $past(latch_n, 3))
        |-> !sdo);

endmodule

bind gain_word_port gwp_checker #(
    .CODE_W    (CODE_W),
    .MAX_CODE  (MAX_CODE),
    .DB_OFFSET (DB_OFFSET)
) u_gwp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_n   (latch_n),
    .sdo       (sdo),
    .gain_code (gain_code),
    .gain_db   (gain_db)
);

// File: tb/gain_word_port_bench.sv
`timescale 1ns/1ps
module gain_word_port_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sclk = 1'b0;
    logic              sdi = 1'b0;
    logic              latch_n = 1'b1;
    logic              sdo;
    logic [5:0]        gain_code;
    logic signed [6:0] gain_db;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gain_word_port u_gain_word_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .latch_n   (latch_n),
        .sdo       (sdo),
        .gain_code (gain_code),
        .gain_db   (gain_db)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends bits[n-1] first. rx[i] holds sdo just before rising edge i+1.
    task automatic frame(input logic [15:0] bits, input int n, output logic [15:0] rx);
        rx = '0;
        @(negedge clk);
        latch_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdi  = bits[n-1-i];
            wait_clk(4);
            rx[i] = sdo;
            sclk = 1'b1;
            wait_clk(4);
        end
        sclk = 1'b0;
        wait_clk(4);
        latch_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic write_code(input logic [5:0] code, input logic dc);
        logic [15:0] rx;
        frame({8'h00, 1'b0, dc, code}, 8, rx);
        chk("R10 sdo during write", int'(rx[7:0]), 0);
    endtask

    task automatic read_code(input logic dc, output logic [5:0] got, output logic [1:0] head);
        logic [15:0] rx;
        frame({8'h00, 1'b1, dc, 6'h00}, 8, rx);
        for (int i = 0; i < 6; i++) got[i] = rx[i+2];
        head = rx[1:0];
    endtask

    task automatic t_reset;
        chk("R1 code", int'(gain_code), 0);
        chk("R1 db", int'(gain_db), -9);
        chk("R1 sdo", int'(sdo), 0);
    endtask

    task automatic t_write_order;
        write_code(6'd1, 1'b0);
        chk("R5 msb-first code 1", int'(gain_code), 1);
        write_code(6'd32, 1'b0);
        chk("R5 msb-first code 32", int'(gain_code), 32);
        chk("R8 db for 32", int'(gain_db), 23);
        write_code(6'd23, 1'b0);
        chk("R3 write mode code 23", int'(gain_code), 23);
        chk("R8 db for 23", int'(gain_db), 14);
    endtask

    task automatic t_spacer;
        logic [5:0] got;
        logic [1:0] head;
        write_code(6'd5, 1'b1);
        chk("R4 spacer 1 on write", int'(gain_code), 5);
        read_code(1'b0, got, head);
        chk("R4 read spacer 0", int'(got), 5);
        read_code(1'b1, got, head);
        chk("R4 read spacer 1", int'(got), 5);
    endtask

    task automatic t_read;
        logic [5:0] got;
        logic [1:0] head;
        write_code(6'd38, 1'b0);
        read_code(1'b0, got, head);
        chk("R9 lsb-first readback 38", int'(got), 38);
        chk("R10 sdo low on mode/spacer", int'(head), 0);
        chk("R9 read keeps code", int'(gain_code), 38);
        write_code(6'd11, 1'b0);
        read_code(1'b0, got, head);
        chk("R9 lsb-first readback 11", int'(got), 11);
        chk("R3 read mode leaves code", int'(gain_code), 11);
        wait_clk(2);
        chk("R10 sdo after read", int'(sdo), 0);
    endtask

    task automatic t_bad_length;
        logic [15:0] rx;
        write_code(6'd20, 1'b0);
        frame({9'h000, 1'b0, 6'd3}, 7, rx);
        chk("R6 short frame kept", int'(gain_code), 20);
        frame({7'h00, 2'b00, 6'd7, 1'b1}, 9, rx);
        chk("R6 long frame kept", int'(gain_code), 20);
        frame(16'h0000, 0, rx);
        chk("R6 empty frame kept", int'(gain_code), 20);
    endtask

    task automatic t_saturate;
        write_code(6'd42, 1'b0);
        chk("R7 code 42 clipped", int'(gain_code), 41);
        write_code(6'd0, 1'b0);
        chk("R8 db floor", int'(gain_db), -9);
        write_code(6'd63, 1'b0);
        chk("R7 code 63 clipped", int'(gain_code), 41);
        chk("R8 db ceiling", int'(gain_db), 32);
        write_code(6'd41, 1'b0);
        chk("R7 code 41 kept", int'(gain_code), 41);
    endtask

    task automatic t_deselected;
        int sdo_hits = 0;
        write_code(6'd17, 1'b0);
        latch_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            sdi  = i[0];
            sclk = 1'b0;
            wait_clk(4);
            sdo_hits += int'(sdo);
            sclk = 1'b1;
            wait_clk(4);
            sdo_hits += int'(sdo);
        end
        sclk = 1'b0;
        wait_clk(6);
        chk("R2 code with latch high", int'(gain_code), 17);
        chk("R2 sdo with latch high", sdo_hits, 0);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_write_order();
        t_spacer();
        t_read();
        t_bad_length();
        t_saturate();
        t_deselected();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule